// File: doc/BRIEF.md
# Runtime Tap-Selectable Separable Interpolator

This block computes a two-dimensional fractional-position interpolation of a pixel block. It applies one FIR filter along each incoming row, then the same filter down each column of the row results. At the start of every block a mode input chooses how many taps the filter uses. The full-length legacy filter gives the best quality. Two shorter approximate filters lower the switching activity, and the block needs fewer input rows and columns to fill its windows. An intra-reference flag overrides the mode and forces the legacy length, so reference pictures never see approximation error.

One datapath serves every mode. Tap stages beyond the selected length are bypassed. Their storage registers have their enables held low, which stands in for a gated clock, and their multiplier operands are forced to zero. Each mode has its own coefficient set on configuration inputs. The mode and its coefficients are captured in the cycle that starts a block and hold until that block has drained. The default parameters describe a luma filter with 8, 5 and 3 taps. A chroma instance uses 4, 3 and 2 taps.

Top module: `approx_interp`

## Requirements
- R1: The tap count N is taken from `modeSel` at block start: 0 selects TAPS_HIGH (8), 1 selects TAPS_MED (5), 2 selects TAPS_LOW (3), and 3 is treated as 0.
- R2: If `intraRef` is high in the block-start cycle, N is TAPS_HIGH and the high coefficient set is used, whatever `modeSel` holds.
- R3: `modeSel`, `intraRef` and the coefficient inputs are sampled only at block start. Changes during a block do not affect it.
- R4: While idle, a pixel with `inValid` and `inStart` high starts a block and is its pixel (0,0). While idle, pixels without `inStart` are ignored. While busy, `inStart` is ignored. After reset `busy` and `outValid` are low.
- R5: A block in N-tap mode takes exactly (BLK_H+N-1) rows of (BLK_W+N-1) unsigned pixels in raster order.
- R6: Coefficient j of a set sits at bits [j*COEF_W +: COEF_W], signed, and multiplies the input sample at offset +j. h(y,x)=sum_j c[j]*p(y,x+j). v(y,x)=sum_j c[j]*h(y+j,x). The output is (v + 2^(OUT_SHIFT-1)) >>> OUT_SHIFT, clipped to 0..2^DATA_W-1.
- R7: Each block yields exactly BLK_W*BLK_H outputs on `outPix`, flagged by `outValid`, in raster order.
- R8: With no input gaps, `busy` stays high for exactly P+2 cycles, where P=(BLK_W+N-1)*(BLK_H+N-1). The last output appears in the final busy cycle, so shorter modes finish sooner.
- R9: Cycles with `inValid` low during a block stall the input and do not change any result.
- R10: Bypassed stages neither load nor contribute. Data left in them by an earlier longer-mode block does not change a shorter-mode result.
- R11: `outValid` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Quality mode, sampled at block start |
| intraRef | input | 1 | Forces the legacy length for this block |
| coefHigh | input | TAPS_HIGH*COEF_W | Legacy coefficient set |
| coefMed | input | TAPS_HIGH*COEF_W | Medium coefficient set (low TAPS_MED entries used) |
| coefLow | input | TAPS_HIGH*COEF_W | Low coefficient set (low TAPS_LOW entries used) |
| inValid | input | 1 | Input pixel valid |
| inStart | input | 1 | Marks the first pixel of a block |
| inPix | input | DATA_W | Input pixel |
| busy | output | 1 | Block in progress, including pipeline drain |
| outValid | output | 1 | Output pixel valid |
| outPix | output | DATA_W | Interpolated, clipped pixel |

## Verification
The assertions check on every cycle that the captured tap count matches the mode and intra flag at each block start, and that it stays fixed while a block runs. They also check that a busy period begins only from a start pixel and that no output appears outside a busy period. The arithmetic itself can only be shown by the bench's scenarios: the separable sums against a reference filter of each length, saturation at both ends, and the geometry of each mode. The same holds for stalls, for ignored mid-block starts and mode changes, and for the absence of leakage from stale data in bypassed stages after a longer-mode block.

// File: rtl/approx_interp_pkg.sv
package approx_interp_pkg;

  typedef enum logic [1:0] {
    MODE_HIGH = 2'd0,
    MODE_MED  = 2'd1,
    MODE_LOW  = 2'd2,
    MODE_ALT  = 2'd3
  } modeE;

  typedef struct packed {
    logic hShift;   // input pixel enters horizontal window
    logic hLoad;    // horizontal result register loads
    logic vLoad;    // line storage updates at vCol
    logic outFire;  // output register loads a valid pixel
  } strobeS;

endpackage

// File: rtl/approx_interp_ctrl.sv
module approx_interp_ctrl
  import approx_interp_pkg::*;
#(
  parameter int COEF_W    = 8,
  parameter int BLK_W     = 8,
  parameter int BLK_H     = 8,
  parameter int TAPS_HIGH = 8,
  parameter int TAPS_MED  = 5,
  parameter int TAPS_LOW  = 3,
  localparam int MAX_TAPS = TAPS_HIGH,
  localparam int TAP_W    = $clog2(MAX_TAPS + 1),
  localparam int POS_W    = $clog2(BLK_W + BLK_H + 2 * MAX_TAPS),
  localparam int VCOL_W   = (BLK_W > 1) ? $clog2(BLK_W) : 1,
  localparam int SET_W    = MAX_TAPS * COEF_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [1:0]                       modeSel,
  input  logic                             intraRef,
  input  logic [SET_W-1:0]                 coefHigh,
  input  logic [SET_W-1:0]                 coefMed,
  input  logic [SET_W-1:0]                 coefLow,
  input  logic                             inValid,
  input  logic                             inStart,
  output logic                             busy,
  output logic [TAP_W-1:0]                 nTaps,
  output strobeS                           strb,
  output logic [MAX_TAPS-1:0]              tapEn,
  output logic [VCOL_W-1:0]                vCol,
  output logic [MAX_TAPS-1:0][COEF_W-1:0]  coefTap
);

  logic [TAP_W-1:0]    selTaps, nEff;
  logic [SET_W-1:0]    setSel;
  logic [MAX_TAPS-1:0] tapEnReg, tapEnNow;
  logic [POS_W-1:0]    colCnt, rowCnt, colNow, rowNow;
  logic                startNow, accept, lastCol, lastRow;
  logic                draining;
  logic [1:0]          drainCnt;
  logic                s1Valid, s2Valid;
  logic [VCOL_W-1:0]   s1Col, s2Col;
  logic [POS_W-1:0]    s1Row, s2Row;

  // Mode decode: intra reference wins, the spare code maps to legacy.
  always_comb begin
    if (intraRef) begin
      selTaps = TAP_W'(TAPS_HIGH);
      setSel  = coefHigh;
    end else begin
      case (modeE'(modeSel))
        MODE_MED: begin selTaps = TAP_W'(TAPS_MED); setSel = coefMed; end
        MODE_LOW: begin selTaps = TAP_W'(TAPS_LOW); setSel = coefLow; end
        default:  begin selTaps = TAP_W'(TAPS_HIGH); setSel = coefHigh; end
      endcase
    end
  end

  always_comb begin
    startNow = !busy && inValid && inStart;
    accept   = startNow || (busy && !draining && inValid);
    nEff     = startNow ? selTaps : nTaps;
    colNow   = startNow ? '0 : colCnt;
    rowNow   = startNow ? '0 : rowCnt;
    lastCol  = (int'(colNow) == BLK_W + int'(nEff) - 2);
    lastRow  = (int'(rowNow) == BLK_H + int'(nEff) - 2);
    for (int k = 0; k < MAX_TAPS; k++) tapEnNow[k] = (k < int'(nEff));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      draining <= 1'b0;
      drainCnt <= '0;
      nTaps    <= TAP_W'(TAPS_HIGH);
      tapEnReg <= '0;
      coefTap  <= '0;
      colCnt   <= '0;
      rowCnt   <= '0;
      s1Valid  <= 1'b0;
      s2Valid  <= 1'b0;
      s1Col    <= '0;
      s2Col    <= '0;
      s1Row    <= '0;
      s2Row    <= '0;
    end else begin
      if (startNow) begin
        busy     <= 1'b1;
        nTaps    <= selTaps;
        tapEnReg <= tapEnNow;
        // Reorder so that tap 0 pairs with the newest sample.
        for (int k = 0; k < MAX_TAPS; k++) begin
          if (k < int'(selTaps))
            coefTap[k] <= setSel[(int'(selTaps) - 1 - k) * COEF_W +: COEF_W];
          else
            coefTap[k] <= '0;
        end
      end
      if (accept) begin
        if (lastCol) begin
          colCnt <= '0;
          rowCnt <= rowNow + 1'b1;
        end else begin
          colCnt <= colNow + 1'b1;
          rowCnt <= rowNow;
        end
        if (lastCol && lastRow) begin
          draining <= 1'b1;
          drainCnt <= 2'd3;
        end
      end
      if (draining) begin
        drainCnt <= drainCnt - 1'b1;
        if (drainCnt == 2'd1) begin
          busy     <= 1'b0;
          draining <= 1'b0;
        end
      end
      s1Valid <= accept && (int'(colNow) >= int'(nEff) - 1);
      s1Col   <= VCOL_W'(int'(colNow) - int'(nEff) + 1);
      s1Row   <= rowNow;
      s2Valid <= s1Valid;
      s2Col   <= s1Col;
      s2Row   <= s1Row;
    end
  end

  always_comb begin
    tapEn        = startNow ? tapEnNow : tapEnReg;
    vCol         = s2Col;
    strb.hShift  = accept;
    strb.hLoad   = s1Valid;
    strb.vLoad   = s2Valid;
    strb.outFire = s2Valid && (int'(s2Row) >= int'(nTaps) - 1);
  end

endmodule

// File: rtl/approx_interp_dp.sv
module approx_interp_dp
  import approx_interp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int COEF_W    = 8,
  parameter int BLK_W     = 8,
  parameter int MAX_TAPS  = 8,
  parameter int OUT_SHIFT = 12,
  localparam int VCOL_W   = (BLK_W > 1) ? $clog2(BLK_W) : 1,
  localparam int HSUM_W   = DATA_W + COEF_W + $clog2(MAX_TAPS) + 1,
  localparam int VSUM_W   = HSUM_W + COEF_W + $clog2(MAX_TAPS) + 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobeS                           strb,
  input  logic [MAX_TAPS-1:0]              tapEn,
  input  logic [VCOL_W-1:0]                vCol,
  input  logic [MAX_TAPS-1:0][COEF_W-1:0]  coefTap,
  input  logic [DATA_W-1:0]                inPix,
  output logic                             outValid,
  output logic [DATA_W-1:0]                outPix
);

  localparam logic signed [VSUM_W-1:0] ROUND_C = VSUM_W'(1) <<< (OUT_SHIFT - 1);
  localparam logic signed [VSUM_W-1:0] PIX_MAX = VSUM_W'((1 << DATA_W) - 1);

  logic [MAX_TAPS-1:0][HSUM_W-1:0] hProd;
  logic [MAX_TAPS-1:0][VSUM_W-1:0] vProd;
  logic signed [HSUM_W-1:0]        hSum, hReg;
  logic signed [VSUM_W-1:0]        vSum, rounded, shifted;

  // Horizontal window: one register per tap stage, enable off when bypassed.
  for (genvar k = 0; k < MAX_TAPS; k++) begin : stageG
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] opPix;
    if (k == 0) begin : headG
      always_ff @(posedge clk)
        if (strb.hShift && tapEn[k]) q <= inPix;
    end else begin : chainG
      always_ff @(posedge clk)
        if (strb.hShift && tapEn[k]) q <= stageG[k-1].q;
    end
    assign opPix    = tapEn[k] ? q : '0;  // operand isolation
    assign hProd[k] = HSUM_W'($signed({1'b0, opPix})) * HSUM_W'($signed(coefTap[k]));
  end

  always_comb begin
    hSum = '0;
    for (int k = 0; k < MAX_TAPS; k++) hSum += $signed(hProd[k]);
  end

  always_ff @(posedge clk)
    if (strb.hLoad) hReg <= hSum;

  // Newest row comes straight from hReg; older rows from line storage.
  assign vProd[0] = VSUM_W'(hReg) * VSUM_W'($signed(coefTap[0]));

  for (genvar r = 0; r < MAX_TAPS - 1; r++) begin : rowG
    logic signed [HSUM_W-1:0] mem [BLK_W];
    logic signed [HSUM_W-1:0] opRow;
    if (r == 0) begin : headG
      always_ff @(posedge clk)
        if (strb.vLoad && tapEn[r+1]) mem[vCol] <= hReg;
    end else begin : chainG
      always_ff @(posedge clk)
        if (strb.vLoad && tapEn[r+1]) mem[vCol] <= rowG[r-1].mem[vCol];
    end
    assign opRow      = tapEn[r+1] ? mem[vCol] : '0;  // operand isolation
    assign vProd[r+1] = VSUM_W'(opRow) * VSUM_W'($signed(coefTap[r+1]));
  end

  always_comb begin
    vSum = '0;
    for (int k = 0; k < MAX_TAPS; k++) vSum += $signed(vProd[k]);
    rounded = vSum + ROUND_C;
    shifted = rounded >>> OUT_SHIFT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= strb.outFire;
      if (strb.outFire) begin
        if (shifted < 0)            outPix <= '0;
        else if (shifted > PIX_MAX) outPix <= PIX_MAX[DATA_W-1:0];
        else                        outPix <= shifted[DATA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/approx_interp.sv
module approx_interp
  import approx_interp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int COEF_W    = 8,
  parameter int BLK_W     = 8,
  parameter int BLK_H     = 8,
  parameter int TAPS_HIGH = 8,
  parameter int TAPS_MED  = 5,
  parameter int TAPS_LOW  = 3,
  parameter int OUT_SHIFT = 12,
  localparam int MAX_TAPS = TAPS_HIGH,
  localparam int TAP_W    = $clog2(MAX_TAPS + 1),
  localparam int VCOL_W   = (BLK_W > 1) ? $clog2(BLK_W) : 1,
  localparam int SET_W    = MAX_TAPS * COEF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              intraRef,
  input  logic [SET_W-1:0]  coefHigh,
  input  logic [SET_W-1:0]  coefMed,
  input  logic [SET_W-1:0]  coefLow,
  input  logic              inValid,
  input  logic              inStart,
  input  logic [DATA_W-1:0] inPix,
  output logic              busy,
  output logic              outValid,
  output logic [DATA_W-1:0] outPix
);

  strobeS                           strb;
  logic [TAP_W-1:0]                 nTaps;
  logic [MAX_TAPS-1:0]              tapEn;
  logic [VCOL_W-1:0]                vCol;
  logic [MAX_TAPS-1:0][COEF_W-1:0]  coefTap;

  approx_interp_ctrl #(
    .COEF_W(COEF_W), .BLK_W(BLK_W), .BLK_H(BLK_H),
    .TAPS_HIGH(TAPS_HIGH), .TAPS_MED(TAPS_MED), .TAPS_LOW(TAPS_LOW)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .intraRef(intraRef),
    .coefHigh(coefHigh), .coefMed(coefMed), .coefLow(coefLow),
    .inValid(inValid), .inStart(inStart), .busy(busy), .nTaps(nTaps),
    .strb(strb), .tapEn(tapEn), .vCol(vCol), .coefTap(coefTap)
  );

  approx_interp_dp #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .BLK_W(BLK_W),
    .MAX_TAPS(MAX_TAPS), .OUT_SHIFT(OUT_SHIFT)
  ) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .tapEn(tapEn), .vCol(vCol),
    .coefTap(coefTap), .inPix(inPix), .outValid(outValid), .outPix(outPix)
  );

endmodule

// File: rtl/approx_interp_chk.sv
module approx_interp_chk #(
  parameter int TAPS_HIGH = 8,
  parameter int TAPS_MED  = 5,
  parameter int TAPS_LOW  = 3,
  localparam int TAP_W    = $clog2(TAPS_HIGH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic             intraRef,
  input logic             inValid,
  input logic             inStart,
  input logic             busy,
  input logic             outValid,
  input logic [TAP_W-1:0] nTaps
);

  logic [TAP_W-1:0] expTaps;
  logic             startReq;

  always_comb begin
    startReq = !busy && inValid && inStart;
    case (modeSel)
      2'd1:    expTaps = TAP_W'(TAPS_MED);
      2'd2:    expTaps = TAP_W'(TAPS_LOW);
      default: expTaps = TAP_W'(TAPS_HIGH);
    endcase
  end

  AST_MODE_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !intraRef) |=> (nTaps == $past(expTaps)));  // R1

  AST_INTRA_LEGACY: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && intraRef) |=> (nTaps == TAP_W'(TAPS_HIGH)));  // R2

  AST_TAPS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(nTaps));  // R3

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(inValid && inStart));  // R4

  AST_OUT_IN_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);  // R11

endmodule

bind approx_interp approx_interp_chk #(
  .TAPS_HIGH(TAPS_HIGH), .TAPS_MED(TAPS_MED), .TAPS_LOW(TAPS_LOW)
) chkI (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .intraRef(intraRef),
  .inValid(inValid), .inStart(inStart), .busy(busy),
  .outValid(outValid), .nTaps(nTaps)
);

// File: tb/tb_approx_interp.sv
module tb_approx_interp;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;
  localparam int BH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic        intraRef = 1'b0;
  logic [63:0] coefHigh = '0, coefMed = '0, coefLow = '0;
  logic        inValid = 1'b0, inStart = 1'b0;
  logic [7:0]  inPix = '0;
  logic        busy, outValid;
  logic [7:0]  outPix;

  int checks = 0;
  int errors = 0;
  int busyCnt = 0;
  int got[$];
  int pix[15][15];
  int cHi[8], cMd[8], cLo[8], cset[8];
  int expv[64];

  always #(CLK_PERIOD/2) clk = ~clk;

  approx_interp dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .intraRef(intraRef),
    .coefHigh(coefHigh), .coefMed(coefMed), .coefLow(coefLow),
    .inValid(inValid), .inStart(inStart), .inPix(inPix),
    .busy(busy), .outValid(outValid), .outPix(outPix)
  );

  always @(negedge clk) begin
    if (busy) busyCnt++;
    if (outValid) got.push_back(int'(outPix));
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic loadCoefs();
    for (int j = 0; j < 8; j++) begin
      coefHigh[j*8 +: 8] = 8'(cHi[j]);
      coefMed[j*8 +: 8]  = 8'(cMd[j]);
      coefLow[j*8 +: 8]  = 8'(cLo[j]);
    end
  endtask

  task automatic fillPix(input int kind);
    for (int y = 0; y < 15; y++)
      for (int x = 0; x < 15; x++)
        pix[y][x] = (kind == 0) ? int'($urandom_range(255)) : ($urandom_range(1) ? 255 : 0);
  endtask

  function automatic int tapsFor(input int m, input bit intra);
    if (intra || m == 0 || m == 3) return 8;
    return (m == 1) ? 5 : 3;
  endfunction

  task automatic calcExp(input int n);
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++) begin
        int v = 0;
        for (int j = 0; j < n; j++) begin
          int h = 0;
          for (int i = 0; i < n; i++) h += cset[i] * pix[y+j][x+i];
          v += cset[j] * h;
        end
        v = (v + 2048) >>> 12;
        expv[y*BW + x] = (v < 0) ? 0 : ((v > 255) ? 255 : v);
      end
  endtask

  // Runs one block and checks values, count and busy length.
  task automatic runBlock(input int m, input bit intra, input bit gaps,
                          input bit midChange, input bit midStart,
                          input bit junk, input string tag);
    int n = tapsFor(m, intra);
    int rows, cols;
    bit sawGap = 0;
    for (int j = 0; j < 8; j++)
      cset[j] = (n == 8) ? cHi[j] : ((n == 5) ? cMd[j] : cLo[j]);
    calcExp(n);
    rows = BH + n - 1;
    cols = BW + n - 1;
    loadCoefs();
    modeSel = 2'(m);
    intraRef = intra;
    got.delete();
    busyCnt = 0;
    if (junk) begin
      for (int i = 0; i < 3; i++) begin
        inValid = 1'b1; inStart = 1'b0; inPix = 8'($urandom_range(255));
        @(negedge clk);
      end
    end
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < cols; x++) begin
        if (gaps && (y + x) > 0 && $urandom_range(3) == 0) begin
          inValid = 1'b0; inStart = 1'b0; sawGap = 1;
          @(negedge clk);
        end
        inValid = 1'b1;
        inPix = 8'(pix[y][x]);
        inStart = (y == 0 && x == 0) || (midStart && y == 2 && x == 1);
        if (midChange && y == 1 && x == 0) begin
          modeSel = 2'(m ^ 2);
          intraRef = !intra;
          cHi[3] = cHi[3] + 5;
          loadCoefs();
        end
        @(negedge clk);
      end
    inValid = 1'b0;
    inStart = 1'b0;
    while (busy) @(negedge clk);
    check(got.size() == BW*BH, {tag, " R7 count"}, got.size(), BW*BH);
    for (int i = 0; i < BW*BH; i++) begin
      int a = (i < got.size()) ? got[i] : -1;
      check(a == expv[i], {tag, " R6 pixel"}, a, expv[i]);
    end
    if (!sawGap)
      check(busyCnt == rows*cols + 2, {tag, " R8 busy cycles"}, busyCnt, rows*cols + 2);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R4 reset busy", int'(busy), 0);
    check(outValid == 1'b0, "R11 reset outValid", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    cHi = '{-1, 4, -11, 40, 40, -11, 4, -1};
    cMd = '{-3, 11, 48, 11, -3, 0, 0, 0};
    cLo = '{8, 48, 8, 0, 0, 0, 0, 0};

    fillPix(0); runBlock(0, 0, 0, 0, 0, 0, "R1 R5 high mode");
    fillPix(0); runBlock(1, 0, 0, 1, 1, 1, "R3 R4 medium with mid changes");
    fillPix(0); runBlock(0, 0, 0, 0, 0, 0, "R1 high refill");
    fillPix(0); runBlock(2, 0, 0, 0, 0, 0, "R10 low after high");
    fillPix(0); runBlock(3, 0, 0, 0, 0, 0, "R1 spare code");
    fillPix(0); runBlock(2, 1, 0, 0, 0, 0, "R2 intra forces legacy");
    fillPix(0); runBlock(1, 0, 1, 0, 0, 0, "R9 medium with gaps");
    fillPix(0); runBlock(2, 0, 1, 0, 0, 0, "R9 low with gaps");

    cLo = '{-100, 127, 20, 0, 0, 0, 0, 0};
    fillPix(1); runBlock(2, 0, 0, 0, 0, 0, "R6 saturation");

    for (int b = 0; b < 6; b++) begin
      for (int j = 0; j < 8; j++) begin
        cHi[j] = int'($urandom_range(255)) - 128;
        cMd[j] = int'($urandom_range(255)) - 128;
        cLo[j] = int'($urandom_range(255)) - 128;
      end
      fillPix(b % 2);
      runBlock(int'($urandom_range(3)), ($urandom_range(3) == 0), bit'($urandom_range(1)),
               0, 0, 0, "R6 R10 random");
    end
    finishRun();
  end

endmodule